// File: doc/BRIEF.md
# Modem Event Status and Interrupt Controller

This block gathers the event strobes of a half-duplex serial modem into a sticky status register and drives one shared, active-low interrupt request line. Five event sources feed it. Two come from the transmit side: the transmitter has gone idle, and the transmit buffer is ready for another byte. Three come from the receive side: a received byte is ready, the sync word was found, and the inverted sync word was found. Each source delivers a one-cycle strobe. The strobe sets a flag, and the flag stays set until the host reads the status register.

The host reads the status register through a read strobe, and that read clears every flag. A control register holds a global interrupt-disable bit. A mode input tells the block whether the modem is transmitting or receiving. A received-byte event that arrives while the modem transmits is still recorded in the status register, but it does not request an interrupt. The interrupt pin is presented as an open-drain pair: a drive-enable and a data value that is always low. Several devices can therefore share one pulled-up line.

Top module: `modem_irq_ctrl`

## Requirements
- R1: After reset, `stat_rdata` reads 0, `ctrl_rdata` reads 0 (interrupts enabled) and `irq_oe` is 0.
- R2: A strobe on an event input sets its status bit in `stat_rdata` from the next clock edge. The bit positions are: bit 0 transmitter idle, bit 1 transmit ready, bit 2 receive ready, bit 3 sync found, bit 4 inverted sync found.
- R3: `stat_rdata` always shows the current flags. A cycle with `stat_rd` high clears all flags at the next edge. An event strobe in the same cycle as the read leaves its own flag set.
- R4: `irq_oe` is 1 exactly when interrupts are enabled and at least one flag is armed. It follows the flags with no further delay. `irq_o` is always 0.
- R5: Writing the control register with `ctrl_we` updates `ctrl_rdata` at the next edge. While bit 3 of the control register is 1, `irq_oe` stays 0 and the flags keep recording. Clearing bit 3 lets pending armed flags drive `irq_oe` again.
- R6: A receive-ready strobe while `mode_rx` is 0 sets status bit 2 without arming it. A later change of `mode_rx` does not arm it. Only a receive-ready strobe while `mode_rx` is 1 arms it. A transmit-mode strobe does not disarm a flag that is already armed. All other flags are armed whenever they are set.
- R7: With no event strobe and no read, the flags hold their value indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| ev_tx_idle | input | 1 | Transmitter idle strobe |
| ev_tx_ready | input | 1 | Transmit buffer ready strobe |
| ev_rx_ready | input | 1 | Received byte ready strobe |
| ev_rx_sync | input | 1 | Sync word found strobe |
| ev_rx_sync_inv | input | 1 | Inverted sync word found strobe |
| mode_rx | input | 1 | 1 = receive mode, 0 = transmit mode |
| stat_rd | input | 1 | Status read strobe (clears flags) |
| stat_rdata | output | 5 | Status register contents |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | CTRL_W | Control register write data |
| ctrl_rdata | output | CTRL_W | Control register contents |
| irq_o | output | 1 | Interrupt pin data, constant 0 |
| irq_oe | output | 1 | Interrupt pin drive enable (1 pulls the line low) |

## Verification
The bench aims at an event that coincides with a status read. A design that gives the clear priority loses that event for good. It checks that a receive-ready event in transmit mode raises no interrupt, and that the flag stays quiet after the mode switches to receive. A design that gates the interrupt with the current mode instead of the mode at the time of the event would fire late. The global disable bit is toggled while flags are pending. A design that clears flags on disable, or that gates the event capture, would then lose the interrupt once it is re-enabled. A long pseudo-random run compares every output against a behavioural model on each clock.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
    localparam int NUM_EVT    = 5;
    localparam int EV_TX_IDLE = 0;
    localparam int EV_TX_RDY  = 1;
    localparam int EV_RX_RDY  = 2;
    localparam int EV_SYNC    = 3;
    localparam int EV_SYNC_N  = 4;

    typedef struct packed {
        logic flag;
        logic quiet;
    } cell_t;
endpackage

// File: rtl/mirq_flag_cell.sv
module mirq_flag_cell #(
    parameter bit GATED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic mode_rx_i,
    output logic flag_o,
    output logic armed_o
);
    import mirq_pkg::*;

    cell_t cell_d, cell_q;
    logic  keep;

    always_comb begin
        cell_d = cell_q;
        keep   = cell_q.flag & ~clr_i;
        if (clr_i) begin
            cell_d.flag  = 1'b0;
            cell_d.quiet = 1'b0;
        end
        if (set_i) begin
            cell_d.flag = 1'b1;
            if (GATED) begin
                if (mode_rx_i)
                    cell_d.quiet = 1'b0;
                else if (!keep)
                    cell_d.quiet = 1'b1;
            end else begin
                cell_d.quiet = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= '0;
        else        cell_q <= cell_d;
    end

    assign flag_o  = cell_q.flag;
    assign armed_o = cell_q.flag & ~cell_q.quiet;
endmodule

// File: rtl/mirq_ctrl_reg.sv
module mirq_ctrl_reg #(
    parameter int                CTRL_W   = 8,
    parameter int                DIS_BIT  = 3,
    parameter logic [CTRL_W-1:0] RST_VAL  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output logic [CTRL_W-1:0] q_o,
    output logic              irq_en_o
);
    logic [CTRL_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i) ctrl_d = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= RST_VAL;
        else        ctrl_q <= ctrl_d;
    end

    assign q_o      = ctrl_q;
    assign irq_en_o = ~ctrl_q[DIS_BIT];
endmodule

// File: rtl/mirq_irq_drive.sv
module mirq_irq_drive #(
    parameter int N = 5
) (
    input  logic [N-1:0] armed_i,
    input  logic         irq_en_i,
    output logic         irq_o,
    output logic         irq_oe
);
    assign irq_oe = irq_en_i & (|armed_i);
    assign irq_o  = 1'b0;
endmodule

// File: rtl/modem_irq_ctrl.sv
module modem_irq_ctrl #(
    parameter int CTRL_W      = 8,
    parameter int IRQ_DIS_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_idle,
    input  logic              ev_tx_ready,
    input  logic              ev_rx_ready,
    input  logic              ev_rx_sync,
    input  logic              ev_rx_sync_inv,
    input  logic              mode_rx,
    input  logic              stat_rd,
    output logic [4:0]        stat_rdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    output logic              irq_o,
    output logic              irq_oe
);
    import mirq_pkg::*;

    logic [NUM_EVT-1:0] ev_vec;
    logic [NUM_EVT-1:0] flags;
    logic [NUM_EVT-1:0] armed;
    logic               irq_en;

    always_comb begin
        ev_vec             = '0;
        ev_vec[EV_TX_IDLE] = ev_tx_idle;
        ev_vec[EV_TX_RDY]  = ev_tx_ready;
        ev_vec[EV_RX_RDY]  = ev_rx_ready;
        ev_vec[EV_SYNC]    = ev_rx_sync;
        ev_vec[EV_SYNC_N]  = ev_rx_sync_inv;
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        mirq_flag_cell #(
            .GATED(i == EV_RX_RDY)
        ) i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (ev_vec[i]),
            .clr_i    (stat_rd),
            .mode_rx_i(mode_rx),
            .flag_o   (flags[i]),
            .armed_o  (armed[i])
        );
    end

    mirq_ctrl_reg #(
        .CTRL_W (CTRL_W),
        .DIS_BIT(IRQ_DIS_BIT),
        .RST_VAL('0)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (ctrl_we),
        .wdata_i (ctrl_wdata),
        .q_o     (ctrl_rdata),
        .irq_en_o(irq_en)
    );

    mirq_irq_drive #(
        .N(NUM_EVT)
    ) i_irq (
        .armed_i (armed),
        .irq_en_i(irq_en),
        .irq_o   (irq_o),
        .irq_oe  (irq_oe)
    );

    assign stat_rdata = flags;
endmodule

// File: rtl/mirq_checker.sv
module mirq_checker #(
    parameter int CTRL_W  = 8,
    parameter int DIS_BIT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        ev,
    input logic              mode_rx,
    input logic              stat_rd,
    input logic [4:0]        stat_rdata,
    input logic [CTRL_W-1:0] ctrl_rdata,
    input logic              irq_oe
);
    for (genvar i = 0; i < 5; i++) begin : g_bit
        // R2: a strobe sets its bit at the next edge
        p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> stat_rdata[i]);
        // R3: a read without a coincident event clears the bit
        p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd && !ev[i]) |=> !stat_rdata[i]);
    end

    // R7: flags hold with no event and no read
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && ev == 5'd0) |=> $stable(stat_rdata));

    // R5: disable bit blocks the pin
    p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[DIS_BIT] |-> !irq_oe);

    // R4: the pin is driven only with a pending flag
    p_need_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_oe |-> (stat_rdata != 5'd0));

    // R6: a lone receive-ready in transmit mode raises no interrupt
    p_tx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == 5'b00100 && !mode_rx && (stat_rdata == 5'd0 || stat_rd)) |=> !irq_oe);
endmodule

bind modem_irq_ctrl mirq_checker #(
    .CTRL_W (CTRL_W),
    .DIS_BIT(IRQ_DIS_BIT)
) i_mirq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        ({ev_rx_sync_inv, ev_rx_sync, ev_rx_ready, ev_tx_ready, ev_tx_idle}),
    .mode_rx   (mode_rx),
    .stat_rd   (stat_rd),
    .stat_rdata(stat_rdata),
    .ctrl_rdata(ctrl_rdata),
    .irq_oe    (irq_oe)
);

// File: tb/test_modem_irq_ctrl.sv
`timescale 1ns/1ps
module test_modem_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] ev = '0;
    logic       mode_rx = 1'b1;
    logic       stat_rd = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [4:0] stat_rdata;
    logic [7:0] ctrl_rdata;
    logic       irq_o, irq_oe;

    int checks = 0;
    int fails = 0;
    bit running = 1'b0;

    // reference state
    bit [4:0] m_flag, m_arm;
    bit [7:0] m_ctrl;

    always #10 clk = ~clk;

    modem_irq_ctrl i_modem_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_idle(ev[0]), .ev_tx_ready(ev[1]), .ev_rx_ready(ev[2]),
        .ev_rx_sync(ev[3]), .ev_rx_sync_inv(ev[4]),
        .mode_rx(mode_rx), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_arm = '0; m_ctrl = '0;
        end else begin
            if (stat_rd) begin m_flag = '0; m_arm = '0; end
            m_flag = m_flag | ev;
            for (int b = 0; b < 5; b++)
                if (ev[b] && (b != 2 || mode_rx)) m_arm[b] = 1'b1;
            if (ctrl_we) m_ctrl = ctrl_wdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (running) begin
            bit exp_irq;
            exp_irq = !m_ctrl[3] && (m_arm != 0);
            chk(stat_rdata == m_flag, "R2/R3 status", stat_rdata, m_flag);
            chk(ctrl_rdata == m_ctrl, "R5 control", ctrl_rdata, m_ctrl);
            chk(irq_oe == exp_irq, "R4 irq_oe", irq_oe, exp_irq);
            chk(irq_o == 1'b0, "R4 irq_o", irq_o, 0);
        end
    end

    task automatic step(input bit [4:0] e, input bit rd);
        @(negedge clk); #1;
        ev = e; stat_rd = rd;
        @(negedge clk); #1;
        ev = '0; stat_rd = 1'b0;
    endtask

    task automatic wr_ctrl(input bit [7:0] v);
        @(negedge clk); #1;
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); #1;
        ctrl_we = 1'b0;
    endtask

    initial begin
        #(20 * 20000);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit [15:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(stat_rdata == 0, "R1 status", stat_rdata, 0);
        chk(ctrl_rdata == 0, "R1 control", ctrl_rdata, 0);
        chk(irq_oe == 0, "R1 irq_oe", irq_oe, 0);
        running = 1'b1;

        // R2: each source alone, then read
        for (int b = 0; b < 5; b++) begin
            step(5'b1 << b, 1'b0);
            chk(stat_rdata == (5'b1 << b), "R2 bit position", stat_rdata, 1 << b);
            chk(irq_oe == 1'b1, "R2 irq", irq_oe, 1);
            step('0, 1'b1);
            chk(stat_rdata == 0, "R3 cleared", stat_rdata, 0);
        end

        // R7: sticky for many idle cycles
        step(5'b01010, 1'b0);
        repeat (20) @(negedge clk);
        chk(stat_rdata == 5'b01010, "R7 hold", stat_rdata, 5'b01010);

        // R3: event coincident with read wins
        step(5'b10000, 1'b1);
        chk(stat_rdata == 5'b10000, "R3 set beats clear", stat_rdata, 5'b10000);
        step('0, 1'b1);

        // R5: disable while flags pending, then re-enable
        wr_ctrl(8'h08);
        step(5'b00001, 1'b0);
        chk(irq_oe == 0, "R5 disabled", irq_oe, 0);
        chk(stat_rdata == 5'b00001, "R5 still records", stat_rdata, 1);
        wr_ctrl(8'hF7);
        chk(ctrl_rdata == 8'hF7, "R5 readback", ctrl_rdata, 8'hF7);
        chk(irq_oe == 1, "R5 re-enabled", irq_oe, 1);
        wr_ctrl(8'h00);
        step('0, 1'b1);

        // R6: receive-ready in transmit mode
        mode_rx = 1'b0;
        step(5'b00100, 1'b0);
        chk(stat_rdata == 5'b00100, "R6 recorded", stat_rdata, 4);
        chk(irq_oe == 0, "R6 quiet", irq_oe, 0);
        mode_rx = 1'b1;
        repeat (3) @(negedge clk);
        chk(irq_oe == 0, "R6 mode change no arm", irq_oe, 0);
        step(5'b00100, 1'b0);
        chk(irq_oe == 1, "R6 rx-mode arms", irq_oe, 1);
        mode_rx = 1'b0;
        step(5'b00100, 1'b0);
        chk(irq_oe == 1, "R6 stays armed", irq_oe, 1);
        step('0, 1'b1);
        step(5'b00110, 1'b0);
        chk(irq_oe == 1, "R6 other flag arms", irq_oe, 1);
        step('0, 1'b1);
        mode_rx = 1'b1;

        // pseudo-random run, model compared each clock
        lfsr = 16'hACE1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ev = lfsr[4:0] & {5{lfsr[5]}} & {lfsr[9], lfsr[8], lfsr[7], lfsr[6], lfsr[11]};
            stat_rd = (lfsr[15:13] == 3'b101);
            mode_rx = lfsr[12] | lfsr[3];
            ctrl_we = (lfsr[10:7] == 4'hF);
            ctrl_wdata = {lfsr[15:12], lfsr[2] & lfsr[14], lfsr[6:4]};
        end
        @(negedge clk); #1;
        ev = '0; stat_rd = 1'b0; ctrl_we = 1'b0;
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule